// File: doc/BRIEF.md
# Guest Exit Condition Filter

This block sits beside the retire stage of a core that can run guest software under a monitor. Each cycle it may see one retiring guest event and, on a separate line, one external interrupt. A guest event is an exception with its vector, an I/O port access, a write to CR0 or CR4, or an instruction of a sensitive class. The block decides whether the event must hand control from the guest to the monitor. If it must, the block raises a one-cycle exit strobe with a 6-bit reason code and a 16-bit qualification word.

The decision is driven by controls that the monitor programs through a small write port:

- an exception bitmap with one bit per vector;
- a per-port I/O bitmap;
- owned-bit masks for CR0 and CR4;
- an enable word for instruction classes;
- a control word whose bit 0 enables exits on host interrupts.

The controls keep their values across exits. They accept writes only while the core runs in root (monitor) mode. The block performs no state save, no instruction decode and no memory access of its own.

Top module: `guest_exit_filter`

## Requirements
- R1: After reset, `exit_valid` is 0 and every control is cleared. With cleared controls, an exception, a port below 1024 or an enabled-class instruction such as HLT (class 6) gives no exit.
- R2: A guest exception with vector v (0..31) exits when bit v of the exception bitmap (address 0x00) is set. The reason is 0 and the qualification is v. Page-fault exits are selected with bit 14.
- R3: I/O ports 0..1023 exit when their bit is set in the I/O bitmap. Word k of the bitmap is at address 0x20+k, and bit b of that word covers port 32k+b. Ports 1024 and above always exit. The reason is 30 and the qualification is the port number.
- R4: A write to CR0 (select 0) or CR4 (select 1) exits only when old XOR new overlaps the owned mask. The CR0 mask is at address 0x02 and the CR4 mask is at address 0x03. The reason is 28 and the qualification is 0 or 4.
- R5: Instruction class c exits when bit c of the enable word (address 0x01) is set. Class 0 (CPUID) always exits. The classes and their reasons are:

  | Class | Instruction | Reason |
  |---|---|---|
  | 0 | CPUID | 10 |
  | 1 | MSR read | 31 |
  | 2 | MSR write | 32 |
  | 3 | counter read | 15 |
  | 4 | timestamp read | 16 |
  | 5 | debug move | 29 |
  | 6 | HLT | 12 |
  | 7 | MWAIT | 36 |
  | 8 | PAUSE | 40 |
  | 9 | CR3 access | 28, qualification 3 |
  | 10 | page invalidate | 14 |

  Classes 11..15 never exit. Where not stated otherwise, the qualification is 0.
- R6: An external interrupt exits with reason 1 and qualification equal to its 8-bit vector, but only when bit 0 of the control word (address 0x04) is set. When that bit is clear, the interrupt gives no exit.
- R7: When an external interrupt exit and a guest event exit fall in the same cycle, only the interrupt exit is reported.
- R8: A control write takes effect only when `cfg_we` and `root_mode` are both 1. In that case it is visible to events from the next cycle on. A write made while `root_mode` is 0 leaves the controls unchanged.
- R9: While `root_mode` is 1, no event and no interrupt produces an exit.
- R10: Each exit is reported one clock after its event and lasts one cycle. Back-to-back events give back-to-back pulses. When no exit is reported, `exit_reason` and `exit_qual` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_mode | input | 1 | 1 while the monitor runs; unlocks writes and suppresses exits |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 32 | Control write data |
| ev_valid | input | 1 | A guest event retires this cycle |
| ev_kind | input | 3 | Event kind: 1 exception, 2 I/O, 3 CR write, 4 instruction |
| ev_vector | input | 5 | Exception vector |
| ev_port | input | 16 | I/O port number |
| ev_insn | input | 4 | Instruction class |
| ev_cr_sel | input | 1 | 0 selects CR0, 1 selects CR4 |
| ev_cr_old | input | CR_W | Register value before the write |
| ev_cr_new | input | CR_W | Value being written |
| ext_irq | input | 1 | External interrupt pending this cycle |
| ext_irq_vec | input | 8 | Vector of that interrupt |
| exit_valid | output | 1 | One-cycle exit strobe |
| exit_reason | output | 6 | Exit reason code |
| exit_qual | output | 16 | Qualification (vector, port or CR index) |

## Verification
Every result of this block is due exactly one rising edge after the cycle that carries its event or interrupt. A control write shows its effect on an event presented one cycle after the write. The bench applies inputs on the falling edge and predicts the exit for that cycle from its own copy of the controls, taken before any write in the same cycle. After the next rising edge, at the following falling edge, it compares the strobe, reason and qualification against that prediction. Because the comparison runs on every cycle, writes, idle cycles and dropped events are all checked for a silent output as well.

// File: rtl/gef_pkg.sv
package gef_pkg;

    localparam int PORT_W = 16;
    localparam int QUAL_W = 16;
    localparam int RSN_W  = 6;
    localparam int VEC_W  = 5;
    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_EXC  = 3'd1,
        EV_IO   = 3'd2,
        EV_CRW  = 3'd3,
        EV_INSN = 3'd4
    } ev_kind_e;

    localparam logic [RSN_W-1:0] RSN_EXC    = 6'd0;
    localparam logic [RSN_W-1:0] RSN_EXTINT = 6'd1;
    localparam logic [RSN_W-1:0] RSN_CPUID  = 6'd10;
    localparam logic [RSN_W-1:0] RSN_HLT    = 6'd12;
    localparam logic [RSN_W-1:0] RSN_PGINV  = 6'd14;
    localparam logic [RSN_W-1:0] RSN_PMCRD  = 6'd15;
    localparam logic [RSN_W-1:0] RSN_TSCRD  = 6'd16;
    localparam logic [RSN_W-1:0] RSN_CR     = 6'd28;
    localparam logic [RSN_W-1:0] RSN_DRMOV  = 6'd29;
    localparam logic [RSN_W-1:0] RSN_IO     = 6'd30;
    localparam logic [RSN_W-1:0] RSN_MSRRD  = 6'd31;
    localparam logic [RSN_W-1:0] RSN_MSRWR  = 6'd32;
    localparam logic [RSN_W-1:0] RSN_MWAIT  = 6'd36;
    localparam logic [RSN_W-1:0] RSN_PAUSE  = 6'd40;

    localparam logic [CFG_AW-1:0] CFG_EXC     = 8'h00;
    localparam logic [CFG_AW-1:0] CFG_INSN    = 8'h01;
    localparam logic [CFG_AW-1:0] CFG_CR0     = 8'h02;
    localparam logic [CFG_AW-1:0] CFG_CR4     = 8'h03;
    localparam logic [CFG_AW-1:0] CFG_CTRL    = 8'h04;
    localparam logic [CFG_AW-1:0] CFG_IO_BASE = 8'h20;

    localparam logic [3:0] IC_CPUID = 4'd0;
    localparam logic [3:0] IC_CR3   = 4'd9;

    typedef struct packed {
        logic              hit;
        logic [RSN_W-1:0]  reason;
        logic [QUAL_W-1:0] qual;
    } exit_cand_t;

    // Returns {known, reason} for an instruction class.
    function automatic logic [RSN_W:0] insn_decode(input logic [3:0] ic);
        case (ic)
            4'd0:    return {1'b1, RSN_CPUID};
            4'd1:    return {1'b1, RSN_MSRRD};
            4'd2:    return {1'b1, RSN_MSRWR};
            4'd3:    return {1'b1, RSN_PMCRD};
            4'd4:    return {1'b1, RSN_TSCRD};
            4'd5:    return {1'b1, RSN_DRMOV};
            4'd6:    return {1'b1, RSN_HLT};
            4'd7:    return {1'b1, RSN_MWAIT};
            4'd8:    return {1'b1, RSN_PAUSE};
            4'd9:    return {1'b1, RSN_CR};
            4'd10:   return {1'b1, RSN_PGINV};
            default: return {1'b0, RSN_EXC};
        endcase
    endfunction

endpackage

// File: rtl/gef_cfg_regs.sv
module gef_cfg_regs
    import gef_pkg::*;
#(
    parameter int IOMAP_PORTS = 1024,
    parameter int CR_W        = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   root_mode,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    output logic [31:0]            exc_map,
    output logic [15:0]            insn_en,
    output logic [CR_W-1:0]        cr0_own,
    output logic [CR_W-1:0]        cr4_own,
    output logic                   host_irq_exit,
    output logic [IOMAP_PORTS-1:0] io_map
);

    localparam int WORDS  = IOMAP_PORTS / 32;
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              wr_ok;
    logic [CFG_AW-1:0] io_off;
    logic              io_sel;
    logic [31:0]       io_words [WORDS];

    assign wr_ok  = cfg_we && root_mode;
    assign io_off = cfg_addr - CFG_IO_BASE;
    assign io_sel = (cfg_addr >= CFG_IO_BASE) && (32'(io_off) < WORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_map       <= '0;
            insn_en       <= '0;
            cr0_own       <= '0;
            cr4_own       <= '0;
            host_irq_exit <= 1'b0;
        end else if (wr_ok) begin
            case (cfg_addr)
                CFG_EXC:  exc_map       <= cfg_wdata;
                CFG_INSN: insn_en       <= cfg_wdata[15:0];
                CFG_CR0:  cr0_own       <= cfg_wdata[CR_W-1:0];
                CFG_CR4:  cr4_own       <= cfg_wdata[CR_W-1:0];
                CFG_CTRL: host_irq_exit <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) io_words[w] <= '0;
        end else if (wr_ok && io_sel) begin
            io_words[io_off[WORD_W-1:0]] <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign io_map[g*32 +: 32] = io_words[g];
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && root_mode) |=> ($stable(exc_map) && $stable(insn_en) &&
        $stable(cr0_own) && $stable(cr4_own) && $stable(host_irq_exit) &&
        $stable(io_map))) else $error("config changed outside root mode"); // R8

endmodule

// File: rtl/gef_match.sv
module gef_match
    import gef_pkg::*;
#(
    parameter int IOMAP_PORTS = 1024,
    parameter int CR_W        = 32
) (
    input  logic                   root_mode,
    input  logic [31:0]            exc_map,
    input  logic [15:0]            insn_en,
    input  logic [CR_W-1:0]        cr0_own,
    input  logic [CR_W-1:0]        cr4_own,
    input  logic                   host_irq_exit,
    input  logic [IOMAP_PORTS-1:0] io_map,
    input  logic                   ev_valid,
    input  ev_kind_e               ev_kind,
    input  logic [VEC_W-1:0]       ev_vector,
    input  logic [PORT_W-1:0]      ev_port,
    input  logic [3:0]             ev_insn,
    input  logic                   ev_cr_sel,
    input  logic [CR_W-1:0]        ev_cr_old,
    input  logic [CR_W-1:0]        ev_cr_new,
    input  logic                   ext_irq,
    input  logic [7:0]             ext_irq_vec,
    output exit_cand_t             ext_c,
    output exit_cand_t             ev_c
);

    localparam int IDX_W = $clog2(IOMAP_PORTS);

    logic            io_hit;
    logic [CR_W-1:0] cr_own;
    logic [RSN_W:0]  ic_dec;

    assign io_hit = (32'(ev_port) >= IOMAP_PORTS) ? 1'b1 : io_map[ev_port[IDX_W-1:0]];
    assign cr_own = ev_cr_sel ? cr4_own : cr0_own;
    assign ic_dec = insn_decode(ev_insn);

    always_comb begin
        ext_c        = '0;
        ext_c.hit    = !root_mode && ext_irq && host_irq_exit;
        ext_c.reason = RSN_EXTINT;
        ext_c.qual   = {8'd0, ext_irq_vec};
    end

    always_comb begin
        ev_c = '0;
        if (!root_mode && ev_valid) begin
            case (ev_kind)
                EV_EXC: begin
                    ev_c.hit    = exc_map[ev_vector];
                    ev_c.reason = RSN_EXC;
                    ev_c.qual   = QUAL_W'(ev_vector);
                end
                EV_IO: begin
                    ev_c.hit    = io_hit;
                    ev_c.reason = RSN_IO;
                    ev_c.qual   = ev_port;
                end
                EV_CRW: begin
                    ev_c.hit    = |((ev_cr_old ^ ev_cr_new) & cr_own);
                    ev_c.reason = RSN_CR;
                    ev_c.qual   = ev_cr_sel ? 16'd4 : 16'd0;
                end
                EV_INSN: begin
                    ev_c.hit    = ic_dec[RSN_W] && ((ev_insn == IC_CPUID) || insn_en[ev_insn]);
                    ev_c.reason = ic_dec[RSN_W-1:0];
                    ev_c.qual   = (ev_insn == IC_CR3) ? 16'd3 : 16'd0;
                end
                default: ev_c = '0;
            endcase
        end
    end

endmodule

// File: rtl/gef_prio.sv
module gef_prio
    import gef_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  exit_cand_t ext_c,
    input  exit_cand_t ev_c,
    output exit_cand_t out_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (ext_c.hit) begin
            out_q <= ext_c;
        end else if (ev_c.hit) begin
            out_q <= ev_c;
        end else begin
            out_q <= '0;
        end
    end

    AST_EXTINT_WINS: assert property (@(posedge clk) disable iff (rst)
        out_q.hit && $past(ext_c.hit) |-> out_q.reason == RSN_EXTINT)
        else $error("interrupt exit lost priority"); // R7

endmodule

// File: rtl/guest_exit_filter.sv
module guest_exit_filter
    import gef_pkg::*;
#(
    parameter int IOMAP_PORTS = 1024,
    parameter int CR_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              root_mode,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [4:0]        ev_vector,
    input  logic [15:0]       ev_port,
    input  logic [3:0]        ev_insn,
    input  logic              ev_cr_sel,
    input  logic [CR_W-1:0]   ev_cr_old,
    input  logic [CR_W-1:0]   ev_cr_new,
    input  logic              ext_irq,
    input  logic [7:0]        ext_irq_vec,
    output logic              exit_valid,
    output logic [5:0]        exit_reason,
    output logic [15:0]       exit_qual
);

    logic [31:0]            exc_map;
    logic [15:0]            insn_en;
    logic [CR_W-1:0]        cr0_own;
    logic [CR_W-1:0]        cr4_own;
    logic                   host_irq_exit;
    logic [IOMAP_PORTS-1:0] io_map;
    exit_cand_t             ext_c;
    exit_cand_t             ev_c;
    exit_cand_t             out_q;

    gef_cfg_regs #(.IOMAP_PORTS(IOMAP_PORTS), .CR_W(CR_W)) u_cfg (
        .clk(clk), .rst(rst), .root_mode(root_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .exc_map(exc_map),
        .insn_en(insn_en), .cr0_own(cr0_own), .cr4_own(cr4_own),
        .host_irq_exit(host_irq_exit), .io_map(io_map)
    );

    gef_match #(.IOMAP_PORTS(IOMAP_PORTS), .CR_W(CR_W)) u_match (
        .root_mode(root_mode), .exc_map(exc_map), .insn_en(insn_en),
        .cr0_own(cr0_own), .cr4_own(cr4_own), .host_irq_exit(host_irq_exit),
        .io_map(io_map), .ev_valid(ev_valid), .ev_kind(ev_kind_e'(ev_kind)),
        .ev_vector(ev_vector), .ev_port(ev_port), .ev_insn(ev_insn),
        .ev_cr_sel(ev_cr_sel), .ev_cr_old(ev_cr_old), .ev_cr_new(ev_cr_new),
        .ext_irq(ext_irq), .ext_irq_vec(ext_irq_vec), .ext_c(ext_c), .ev_c(ev_c)
    );

    gef_prio u_prio (
        .clk(clk), .rst(rst), .ext_c(ext_c), .ev_c(ev_c), .out_q(out_q)
    );

    assign exit_valid  = out_q.hit;
    assign exit_reason = out_q.reason;
    assign exit_qual   = out_q.qual;

    AST_ROOT_NO_EXIT: assert property (@(posedge clk) disable iff (rst)
        exit_valid |-> $past(!root_mode)) else $error("exit from root mode"); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        exit_valid |-> $past(ev_valid || ext_irq)) else $error("exit without cause"); // R10

    AST_EXC_QUAL: assert property (@(posedge clk) disable iff (rst)
        exit_valid && exit_reason == RSN_EXC |-> exit_qual < 16'd32)
        else $error("exception qualification out of range"); // R2

endmodule

// File: tb/guest_exit_filter_bench.sv
module guest_exit_filter_bench;

    localparam int NPORTS = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [4:0]  ev_vector = '0;
    logic [15:0] ev_port = '0;
    logic [3:0]  ev_insn = '0;
    logic        ev_cr_sel = 1'b0;
    logic [31:0] ev_cr_old = '0;
    logic [31:0] ev_cr_new = '0;
    logic        ext_irq = 1'b0;
    logic [7:0]  ext_irq_vec = '0;
    logic        exit_valid;
    logic [5:0]  exit_reason;
    logic [15:0] exit_qual;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    bit [31:0] m_exc;
    bit [15:0] m_insn;
    bit [31:0] m_cr0;
    bit [31:0] m_cr4;
    bit        m_host;
    bit        m_io [NPORTS];

    always #4 clk = ~clk;

    guest_exit_filter u_guest_exit_filter (
        .clk(clk), .rst(rst), .root_mode(root_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_vector(ev_vector), .ev_port(ev_port),
        .ev_insn(ev_insn), .ev_cr_sel(ev_cr_sel), .ev_cr_old(ev_cr_old),
        .ev_cr_new(ev_cr_new), .ext_irq(ext_irq), .ext_irq_vec(ext_irq_vec),
        .exit_valid(exit_valid), .exit_reason(exit_reason), .exit_qual(exit_qual)
    );

    function automatic bit [6:0] insn_ref(input bit [3:0] ic);
        case (ic)
            0: return {1'b1, 6'd10};
            1: return {1'b1, 6'd31};
            2: return {1'b1, 6'd32};
            3: return {1'b1, 6'd15};
            4: return {1'b1, 6'd16};
            5: return {1'b1, 6'd29};
            6: return {1'b1, 6'd12};
            7: return {1'b1, 6'd36};
            8: return {1'b1, 6'd40};
            9: return {1'b1, 6'd28};
            10: return {1'b1, 6'd14};
            default: return 7'd0;
        endcase
    endfunction

    task automatic predict(output bit v, output bit [5:0] r, output bit [15:0] q);
        bit [6:0] d;
        v = 0; r = 0; q = 0;
        if (root_mode) return;
        if (ext_irq && m_host) begin
            v = 1; r = 6'd1; q = {8'd0, ext_irq_vec}; return;
        end
        if (!ev_valid) return;
        case (ev_kind)
            3'd1: if (m_exc[ev_vector]) begin v = 1; r = 6'd0; q = 16'(ev_vector); end
            3'd2: if (ev_port >= NPORTS || m_io[ev_port]) begin v = 1; r = 6'd30; q = ev_port; end
            3'd3: if (((ev_cr_old ^ ev_cr_new) & (ev_cr_sel ? m_cr4 : m_cr0)) != 0) begin
                      v = 1; r = 6'd28; q = ev_cr_sel ? 16'd4 : 16'd0;
                  end
            3'd4: begin
                d = insn_ref(ev_insn);
                if (d[6] && (ev_insn == 0 || m_insn[ev_insn])) begin
                    v = 1; r = d[5:0]; q = (ev_insn == 9) ? 16'd3 : 16'd0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic model_write();
        if (!(cfg_we && root_mode)) return;
        case (cfg_addr)
            8'h00: m_exc  = cfg_wdata;
            8'h01: m_insn = cfg_wdata[15:0];
            8'h02: m_cr0  = cfg_wdata;
            8'h03: m_cr4  = cfg_wdata;
            8'h04: m_host = cfg_wdata[0];
            default: if (cfg_addr >= 8'h20 && cfg_addr < 8'h40)
                for (int b = 0; b < 32; b++) m_io[(cfg_addr - 8'h20) * 32 + b] = cfg_wdata[b];
        endcase
    endtask

    task automatic step(input string tag);
        bit v; bit [5:0] r; bit [15:0] q;
        predict(v, r, q);
        model_write();
        @(posedge clk);
        @(negedge clk);
        tests++;
        if (exit_valid !== v || exit_reason !== r || exit_qual !== q) begin
            fails++;
            $display("FAIL %s: got valid=%0b reason=%0d qual=%0d, expected valid=%0b reason=%0d qual=%0d",
                     tag, exit_valid, exit_reason, exit_qual, v, r, q);
        end
        cfg_we = 0; ev_valid = 0; ext_irq = 0;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(tag);
    endtask

    task automatic exc(input bit [4:0] v, input string tag);
        ev_valid = 1; ev_kind = 3'd1; ev_vector = v; step(tag);
    endtask

    task automatic io(input bit [15:0] p, input string tag);
        ev_valid = 1; ev_kind = 3'd2; ev_port = p; step(tag);
    endtask

    task automatic crw(input bit s, input bit [31:0] o, input bit [31:0] n, input string tag);
        ev_valid = 1; ev_kind = 3'd3; ev_cr_sel = s; ev_cr_old = o; ev_cr_new = n; step(tag);
    endtask

    task automatic insn(input bit [3:0] c, input string tag);
        ev_valid = 1; ev_kind = 3'd4; ev_insn = c; step(tag);
    endtask

    task automatic irq(input bit [7:0] v, input string tag);
        ext_irq = 1; ext_irq_vec = v; step(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_exc = 0; m_insn = 0; m_cr0 = 0; m_cr4 = 0; m_host = 0;
        for (int i = 0; i < NPORTS; i++) m_io[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: cleared controls
        step("R1");
        exc(5'd14, "R1");
        io(16'd5, "R1");
        insn(4'd6, "R1");
        irq(8'h20, "R1");
        // R5: CPUID exits unconditionally
        insn(4'd0, "R5");
        // R8: program in root mode
        root_mode = 1;
        wr(8'h00, 32'h0000_4008, "R8");
        wr(8'h01, 32'h0000_0244, "R8");
        wr(8'h02, 32'h0000_0001, "R8");
        wr(8'h03, 32'h0000_0020, "R8");
        wr(8'h21, 32'h0000_0004, "R8");
        root_mode = 0;
        // R2
        exc(5'd14, "R2");
        exc(5'd5, "R2");
        exc(5'd3, "R2");
        exc(5'd31, "R2");
        // R8: guest-mode writes ignored
        wr(8'h00, 32'hFFFF_FFFF, "R8");
        exc(5'd5, "R8");
        wr(8'h04, 32'h1, "R8");
        irq(8'h33, "R8");
        // R3
        io(16'd34, "R3");
        io(16'd35, "R3");
        io(16'd1023, "R3");
        io(16'd1024, "R3");
        io(16'd2000, "R3");
        io(16'hFFFF, "R3");
        // R4
        crw(1'b0, 32'h0, 32'h2, "R4");
        crw(1'b0, 32'h0, 32'h3, "R4");
        crw(1'b1, 32'h20, 32'h0, "R4");
        crw(1'b1, 32'h1, 32'h0, "R4");
        crw(1'b0, 32'h1, 32'h1, "R4");
        // R5
        insn(4'd6, "R5");
        insn(4'd8, "R5");
        insn(4'd2, "R5");
        insn(4'd1, "R5");
        insn(4'd9, "R5");
        insn(4'd12, "R5");
        // R6
        irq(8'h31, "R6");
        root_mode = 1;
        wr(8'h04, 32'h1, "R6");
        wr(8'h01, 32'h0000_FFFF, "R5");
        root_mode = 0;
        irq(8'h31, "R6");
        insn(4'd8, "R5");
        insn(4'd10, "R5");
        insn(4'd7, "R5");
        insn(4'd15, "R5");
        // R7
        ext_irq = 1; ext_irq_vec = 8'h40; ev_valid = 1; ev_kind = 3'd1; ev_vector = 5'd14;
        step("R7");
        ext_irq = 1; ext_irq_vec = 8'h41; ev_valid = 1; ev_kind = 3'd2; ev_port = 16'd34;
        step("R7");
        exc(5'd14, "R7");
        // R9
        root_mode = 1;
        exc(5'd14, "R9");
        insn(4'd0, "R9");
        irq(8'h22, "R9");
        io(16'd3000, "R9");
        root_mode = 0;
        // R10: back-to-back pulses then silence
        exc(5'd3, "R10");
        io(16'd34, "R10");
        insn(4'd0, "R10");
        step("R10");
        step("R10");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule